// File: doc/BRIEF.md
# Clock Reference Source Selector

This block chooses the timing reference used for outgoing frames. There are four candidate sources, grouped as two pairs. Sources 0 and 1 form the internal pair, and sources 2 and 3 form the external pair. Each pair runs its own copy of the same selection logic. For each candidate the selector uses a quality code, a user priority and an alarm flag. The quality code is either the one received with the source or a value written by software.

Each pair reports three things:
- the chosen member of the pair;
- a clock mode: locked, holdover or free-running;
- the quality code to insert into outgoing frames.

A source that recovers from an alarm is held back for a programmable wait-to-restore time, counted with a 1 Hz tick, before it can be selected again. Holdover is left when the holdover-valid input drops or a programmable holdover timeout expires. In both cases the pair moves to free-running. Software can also force free-running at any time.

All outputs are registered. A change on an input appears on the outputs one clock edge after the edge at which the change is seen.

Top module: `clk_ref_sel`

## Requirements
- R1: When both members of a pair are eligible, the member with the numerically lower effective quality code is selected (sel bit 0 = member A, 1 = member B), and the pair's mode reads locked (code 0).
- R2: When both eligible members have equal quality codes, the member with the larger priority field is selected. When the priority fields are also equal, member A is selected.
- R3: A source's effective quality is its received 4-bit code, unless the override-enable bit (bit 4 of that source's register) is set. In that case the effective quality is the override code in bits 3:0. The priority field sits in bits 6:5. Source registers are at addresses 0 to 3, in source order.
- R4: A source is ineligible while its alarm is high, and also while its effective quality is 15 (the do-not-use code). When only one member of a pair is eligible, that member is selected.
- R5: After a source's alarm falls, the source stays ineligible until the number of 1 Hz ticks seen with the alarm low reaches the wait-to-restore value (address 4, bits 9:0, in seconds, meant for 0 to 720). An alarm during the wait restarts the count from zero.
- R6: A pair that is locked and loses all eligible members enters holdover (code 1) if its holdover-valid input is high. In holdover its quality output is 4'hA.
- R7: A pair is free-running (code 2, quality output 4'hB) under any of these conditions:
  - during reset;
  - while the force bit (address 6, bit 0) is set;
  - when holdover is needed or active while its holdover-valid input is low;
  - once the number of ticks counted in holdover reaches the holdover timeout (address 5, bits 9:0).
- R8: From holdover or free-running, a pair returns to locked on the edge after any member becomes eligible, unless forced. This takes precedence over a holdover timeout that falls due on the same edge.
- R9: While locked, a pair's quality output equals the effective quality code of the member it selects.
- R10: The two pairs are independent. Pair 0 uses sources 0 and 1 and owns sel_o[0], mode_o[1:0] and ql_o[3:0]. Pair 1 uses sources 2 and 3 and owns sel_o[1], mode_o[3:2] and ql_o[7:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_ql_i | input | 16 | Received quality code per source, 4 bits each, source 0 in bits 3:0 |
| alarm_i | input | 4 | Alarm flag per source |
| tick_1hz_i | input | 1 | One-cycle pulse, once per second |
| ho_ok_i | input | 2 | Holdover-valid input per pair |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | 10 | Register write data |
| sel_o | output | 2 | Selected member per pair |
| mode_o | output | 4 | Clock mode per pair: 0 locked, 1 holdover, 2 free-running |
| ql_o | output | 8 | Quality code to insert in outgoing frames, per pair |

## Verification
The most delicate coincidence is a source's wait-to-restore finishing on the same edge as the pair's holdover timeout falls due. The bench provokes it deliberately:
1. Park a pair in holdover one tick short of its timeout, with a wait-to-restore of zero.
2. Drop the alarm and pulse the last tick in the same cycle.
3. On the next edge the recovered source becomes eligible at the moment the timeout expires.

The pair must read locked on the recovered source, not free-running. A second coincidence is an alarm arriving during a wait-to-restore. The bench confirms that the restart is counted from the new alarm, by checking the selection one tick before and one tick after the restarted window ends.

// File: rtl/clk_ref_pkg.sv
package clk_ref_pkg;
  typedef enum logic [1:0] {
    MODE_LOCKED = 2'd0,
    MODE_HOLD   = 2'd1,
    MODE_FREE   = 2'd2
  } clk_mode_e;
endpackage

// File: rtl/clk_ref_cfg.sv
module clk_ref_cfg #(
  parameter int NSRC    = 4,
  parameter int QL_W    = 4,
  parameter int PRIO_W  = 2,
  parameter int TMR_W   = 10,
  parameter int AW      = 3,
  parameter int DW      = 10,
  parameter int WTR_DEF = 300,
  parameter int HO_DEF  = 600
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [NSRC-1:0]          ovr_en_o,
  output logic [NSRC*QL_W-1:0]     ovr_ql_o,
  output logic [NSRC*PRIO_W-1:0]   prio_o,
  output logic [TMR_W-1:0]         wtr_o,
  output logic [TMR_W-1:0]         ho_to_o,
  output logic                     force_o
);
  localparam int EN_BIT   = QL_W;
  localparam int PRIO_LSB = QL_W + 1;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ovr_en_o[s]                   <= 1'b0;
        ovr_ql_o[s*QL_W +: QL_W]      <= '0;
        prio_o[s*PRIO_W +: PRIO_W]    <= '0;
      end else if (we_i && addr_i == AW'(s)) begin
        ovr_ql_o[s*QL_W +: QL_W]      <= wdata_i[QL_W-1:0];
        ovr_en_o[s]                   <= wdata_i[EN_BIT];
        prio_o[s*PRIO_W +: PRIO_W]    <= wdata_i[PRIO_LSB +: PRIO_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wtr_o   <= TMR_W'(WTR_DEF);
      ho_to_o <= TMR_W'(HO_DEF);
      force_o <= 1'b0;
    end else if (we_i) begin
      if (addr_i == AW'(NSRC))     wtr_o   <= wdata_i[TMR_W-1:0];
      if (addr_i == AW'(NSRC + 1)) ho_to_o <= wdata_i[TMR_W-1:0];
      if (addr_i == AW'(NSRC + 2)) force_o <= wdata_i[0];
    end
  end
endmodule

// File: rtl/clk_ref_wtr.sv
module clk_ref_wtr #(
  parameter int TMR_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alarm_i,
  input  logic             tick_i,
  input  logic [TMR_W-1:0] wtr_i,
  output logic             hold_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o <= 1'b0;
      cnt_q  <= '0;
    end else if (alarm_i) begin
      hold_o <= 1'b1;
      cnt_q  <= '0;
    end else if (hold_o) begin
      if (cnt_q >= wtr_i) hold_o <= 1'b0;
      else if (tick_i)    cnt_q  <= cnt_q + 1'b1;
    end
  end

  p_alarm_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_i |=> (hold_o && cnt_q == '0));
  p_release_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && alarm_i) |=> hold_o);
endmodule

// File: rtl/clk_ref_pair.sv
module clk_ref_pair
  import clk_ref_pkg::*;
#(
  parameter int          QL_W    = 4,
  parameter int          PRIO_W  = 2,
  parameter int          TMR_W   = 10,
  parameter logic [3:0]  DNU_QL  = 4'hF,
  parameter logic [3:0]  HOLD_QL = 4'hA,
  parameter logic [3:0]  FREE_QL = 4'hB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [QL_W-1:0]   ql_a_i,
  input  logic [QL_W-1:0]   ql_b_i,
  input  logic [PRIO_W-1:0] prio_a_i,
  input  logic [PRIO_W-1:0] prio_b_i,
  input  logic [1:0]        alarm_i,
  input  logic [1:0]        wtr_hold_i,
  input  logic              tick_i,
  input  logic              ho_ok_i,
  input  logic [TMR_W-1:0]  ho_to_i,
  input  logic              force_i,
  output logic              sel_o,
  output logic [1:0]        mode_o,
  output logic [QL_W-1:0]   ql_o
);
  clk_mode_e        mode_q, mode_n;
  logic [TMR_W-1:0] ho_cnt_q;
  logic [1:0]       elig;
  logic             any_elig, pick_b;
  logic [QL_W-1:0]  ql_n;

  assign elig[0]  = !alarm_i[0] && !wtr_hold_i[0] && (ql_a_i != QL_W'(DNU_QL));
  assign elig[1]  = !alarm_i[1] && !wtr_hold_i[1] && (ql_b_i != QL_W'(DNU_QL));
  assign any_elig = |elig;
  // lower code ranks first, larger priority breaks ties, A wins a full tie
  assign pick_b = elig[1] && (!elig[0] || (ql_b_i < ql_a_i) ||
                  ((ql_b_i == ql_a_i) && (prio_b_i > prio_a_i)));

  always_comb begin
    mode_n = mode_q;
    if (force_i)       mode_n = MODE_FREE;
    else if (any_elig) mode_n = MODE_LOCKED;
    else begin
      unique case (mode_q)
        MODE_LOCKED: mode_n = ho_ok_i ? MODE_HOLD : MODE_FREE;
        MODE_HOLD:   if (!ho_ok_i || ho_cnt_q >= ho_to_i) mode_n = MODE_FREE;
        default:     mode_n = MODE_FREE;
      endcase
    end
  end

  always_comb begin
    unique case (mode_n)
      MODE_LOCKED: ql_n = pick_b ? ql_b_i : ql_a_i;
      MODE_HOLD:   ql_n = QL_W'(HOLD_QL);
      default:     ql_n = QL_W'(FREE_QL);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_FREE;
      sel_o    <= 1'b0;
      ql_o     <= QL_W'(FREE_QL);
      ho_cnt_q <= '0;
    end else begin
      mode_q <= mode_n;
      ql_o   <= ql_n;
      if (any_elig) sel_o <= pick_b;
      if (mode_q != MODE_HOLD)                   ho_cnt_q <= '0;
      else if (tick_i && ho_cnt_q < ho_to_i)     ho_cnt_q <= ho_cnt_q + 1'b1;
    end
  end

  assign mode_o = mode_q;

  p_force_free_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> (mode_q == MODE_FREE && ql_o == QL_W'(FREE_QL)));
  p_hold_lost_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_HOLD && !ho_ok_i && !any_elig) |=> mode_q == MODE_FREE);
  p_relock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_elig && !force_i) |=> mode_q == MODE_LOCKED);
  p_enter_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_LOCKED && !any_elig && ho_ok_i && !force_i) |=>
      (mode_q == MODE_HOLD && ql_o == QL_W'(HOLD_QL)));
  p_sel_eligible_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_elig && !force_i && elig != 2'b11) |=> sel_o == $past(elig[1]));
endmodule

// File: rtl/clk_ref_sel.sv
module clk_ref_sel #(
  parameter int         NPAIR   = 2,
  parameter int         QL_W    = 4,
  parameter int         PRIO_W  = 2,
  parameter int         TMR_W   = 10,
  parameter int         AW      = 3,
  parameter int         WTR_DEF = 300,
  parameter int         HO_DEF  = 600,
  parameter logic [3:0] DNU_QL  = 4'hF,
  parameter logic [3:0] HOLD_QL = 4'hA,
  parameter logic [3:0] FREE_QL = 4'hB,
  parameter int         NSRC    = 2 * NPAIR,
  parameter int         SRC_W   = QL_W + 1 + PRIO_W,
  parameter int         DW      = (TMR_W > SRC_W) ? TMR_W : SRC_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NSRC*QL_W-1:0]   rx_ql_i,
  input  logic [NSRC-1:0]        alarm_i,
  input  logic                   tick_1hz_i,
  input  logic [NPAIR-1:0]       ho_ok_i,
  input  logic                   cfg_we_i,
  input  logic [AW-1:0]          cfg_addr_i,
  input  logic [DW-1:0]          cfg_wdata_i,
  output logic [NPAIR-1:0]       sel_o,
  output logic [2*NPAIR-1:0]     mode_o,
  output logic [NPAIR*QL_W-1:0]  ql_o
);
  logic [NSRC-1:0]        ovr_en, wtr_hold;
  logic [NSRC*QL_W-1:0]   ovr_ql, eff_ql;
  logic [NSRC*PRIO_W-1:0] prio;
  logic [TMR_W-1:0]       wtr_sec, ho_to;
  logic                   force_free;

  clk_ref_cfg #(
    .NSRC(NSRC), .QL_W(QL_W), .PRIO_W(PRIO_W), .TMR_W(TMR_W), .AW(AW), .DW(DW),
    .WTR_DEF(WTR_DEF), .HO_DEF(HO_DEF)
  ) i_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .ovr_en_o(ovr_en), .ovr_ql_o(ovr_ql), .prio_o(prio),
    .wtr_o(wtr_sec), .ho_to_o(ho_to), .force_o(force_free)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign eff_ql[s*QL_W +: QL_W] = ovr_en[s] ? ovr_ql[s*QL_W +: QL_W]
                                              : rx_ql_i[s*QL_W +: QL_W];
    clk_ref_wtr #(.TMR_W(TMR_W)) i_wtr (
      .clk_i, .rst_ni, .alarm_i(alarm_i[s]), .tick_i(tick_1hz_i),
      .wtr_i(wtr_sec), .hold_o(wtr_hold[s])
    );
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    clk_ref_pair #(
      .QL_W(QL_W), .PRIO_W(PRIO_W), .TMR_W(TMR_W),
      .DNU_QL(DNU_QL), .HOLD_QL(HOLD_QL), .FREE_QL(FREE_QL)
    ) i_pair (
      .clk_i, .rst_ni,
      .ql_a_i(eff_ql[(2*p)*QL_W +: QL_W]),
      .ql_b_i(eff_ql[(2*p+1)*QL_W +: QL_W]),
      .prio_a_i(prio[(2*p)*PRIO_W +: PRIO_W]),
      .prio_b_i(prio[(2*p+1)*PRIO_W +: PRIO_W]),
      .alarm_i(alarm_i[2*p +: 2]),
      .wtr_hold_i(wtr_hold[2*p +: 2]),
      .tick_i(tick_1hz_i),
      .ho_ok_i(ho_ok_i[p]),
      .ho_to_i(ho_to),
      .force_i(force_free),
      .sel_o(sel_o[p]),
      .mode_o(mode_o[2*p +: 2]),
      .ql_o(ql_o[p*QL_W +: QL_W])
    );
  end
endmodule

// File: tb/test_clk_ref_sel.sv
module test_clk_ref_sel;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] rx_ql_i = 16'h4444;
  logic [3:0]  alarm_i = 4'hF;
  logic        tick_1hz_i = 1'b0;
  logic [1:0]  ho_ok_i = 2'b11;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_addr_i = '0;
  logic [9:0]  cfg_wdata_i = '0;
  logic [1:0]  sel_o;
  logic [3:0]  mode_o;
  logic [7:0]  ql_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clk_ref_sel i_clk_ref_sel (
    .clk_i(clk), .rst_ni, .rx_ql_i, .alarm_i, .tick_1hz_i, .ho_ok_i,
    .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .sel_o, .mode_o, .ql_o
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [9:0] d);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    step(1);
    cfg_we_i = 1'b0;
  endtask

  task automatic tick();
    tick_1hz_i = 1'b1; step(1); tick_1hz_i = 1'b0; step(1);
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // pair 0 view {sel, mode, ql}
  function automatic logic [6:0] p0();
    return {sel_o[0], mode_o[1:0], ql_o[3:0]};
  endfunction
  function automatic logic [6:0] p1();
    return {sel_o[1], mode_o[3:2], ql_o[7:4]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic last_sel;
    step(3);
    // R7: reset state is free-running with free-run quality
    chk("R7 reset", {sel_o, mode_o, ql_o}, {2'b00, 4'b1010, 8'hBB});
    rst_ni = 1'b1;
    step(2);
    chk("R7 free stays free with all alarmed", {mode_o, ql_o}, {4'b1010, 8'hBB});
    wr(3'd4, 10'd0);
    wr(3'd5, 10'd5);
    alarm_i = 4'h0;
    step(3);
    // R8, R10: both pairs lock, ties go to A
    chk("R8 lock after release p0", p0(), {1'b0, 2'd0, 4'h4});
    chk("R10 lock after release p1", p1(), {1'b0, 2'd0, 4'h4});

    // R1 R2 R4 R9 sweep on pair 0
    last_sel = 1'b0;
    for (int pa = 0; pa < 4; pa++) begin
      for (int pb = 0; pb < 4; pb++) begin
        wr(3'd0, {3'b000, 2'(pa), 1'b0, 4'h0});
        wr(3'd1, {3'b000, 2'(pb), 1'b0, 4'h0});
        for (int qa = 0; qa < 16; qa++) begin
          for (int qb = 0; qb < 16; qb++) begin
            logic ea, eb, pk;
            logic [6:0] exp;
            rx_ql_i[3:0] = 4'(qa);
            rx_ql_i[7:4] = 4'(qb);
            step(2);
            ea = (qa != 15);
            eb = (qb != 15);
            pk = eb && (!ea || qb < qa || (qb == qa && pb > pa));
            if (ea || eb) begin
              last_sel = pk;
              exp = {pk, 2'd0, pk ? 4'(qb) : 4'(qa)};
            end else exp = {last_sel, 2'd1, 4'hA};
            chk("R1 R2 R4 R9 sweep p0", p0(), exp);
            chk("R10 p1 untouched", p1(), {1'b0, 2'd0, 4'h4});
          end
        end
      end
    end

    // R4 alarm sweep: A=5, B=2, equal priority
    wr(3'd0, 10'd0); wr(3'd1, 10'd0);
    rx_ql_i[7:0] = 8'h25;
    for (int al = 0; al < 4; al++) begin
      logic [6:0] exp;
      alarm_i[1:0] = 2'(al);
      step(3);
      case (al)
        0: exp = {1'b1, 2'd0, 4'h2};
        1: exp = {1'b1, 2'd0, 4'h2};
        2: exp = {1'b0, 2'd0, 4'h5};
        default: exp = {1'b0, 2'd1, 4'hA};
      endcase
      chk("R4 alarm sweep", p0(), exp);
    end
    alarm_i = 4'h0;
    step(3);

    // R3 override
    wr(3'd0, {3'b000, 2'd0, 1'b1, 4'h1});
    step(2);
    chk("R3 override better", p0(), {1'b0, 2'd0, 4'h1});
    wr(3'd1, {3'b000, 2'd0, 1'b1, 4'hF});
    wr(3'd0, {3'b000, 2'd0, 1'b0, 4'h1});
    step(2);
    chk("R3 override to do-not-use", p0(), {1'b0, 2'd0, 4'h5});
    wr(3'd1, 10'd0);
    step(2);
    chk("R3 override off", p0(), {1'b1, 2'd0, 4'h2});

    // R5 wait-to-restore with restart
    wr(3'd4, 10'd3);
    rx_ql_i[7:0] = 8'h21;
    alarm_i[0] = 1'b1; step(2);
    alarm_i[0] = 1'b0; step(2);
    chk("R5 held after clear", p0(), {1'b1, 2'd0, 4'h2});
    tick(); tick(); step(2);
    chk("R5 held two ticks", p0(), {1'b1, 2'd0, 4'h2});
    alarm_i[0] = 1'b1; step(1); alarm_i[0] = 1'b0; step(1);
    tick(); tick(); step(2);
    chk("R5 restart held", p0(), {1'b1, 2'd0, 4'h2});
    tick(); step(3);
    chk("R5 restored", p0(), {1'b0, 2'd0, 4'h1});

    // R6 holdover and R7 timeout
    wr(3'd4, 10'd0);
    alarm_i[1:0] = 2'b11; step(2);
    chk("R6 holdover", p0(), {1'b0, 2'd1, 4'hA});
    chk("R10 p1 locked during p0 holdover", p1(), {1'b0, 2'd0, 4'h4});
    tick(); tick(); tick(); tick(); step(1);
    chk("R7 before timeout", p0(), {1'b0, 2'd1, 4'hA});
    tick(); step(2);
    chk("R7 timeout", p0(), {1'b0, 2'd2, 4'hB});
    alarm_i[1:0] = 2'b00; step(3);
    chk("R8 relock from free", p0(), {1'b0, 2'd0, 4'h1});

    // R8 coincidence: restore and timeout due on the same edge
    alarm_i[1:0] = 2'b11; step(2);
    tick(); tick(); tick(); tick();
    alarm_i[0] = 1'b0; tick_1hz_i = 1'b1; step(1); tick_1hz_i = 1'b0;
    step(2);
    chk("R8 restore beats timeout", p0(), {1'b0, 2'd0, 4'h1});

    // R7 holdover-valid drop
    alarm_i[1:0] = 2'b11; step(2);
    chk("R6 holdover again", p0(), {1'b0, 2'd1, 4'hA});
    ho_ok_i[0] = 1'b0; step(2);
    chk("R7 holdover invalid", p0(), {1'b0, 2'd2, 4'hB});
    alarm_i[1:0] = 2'b00; step(3);
    alarm_i[1:0] = 2'b11; step(2);
    chk("R7 lock to free without holdover", p0(), {1'b0, 2'd2, 4'hB});
    alarm_i[1:0] = 2'b00; ho_ok_i[0] = 1'b1; step(3);

    // R7 force
    wr(3'd6, 10'd1); step(1);
    chk("R7 forced free", {mode_o, ql_o}, {4'b1010, 8'hBB});
    wr(3'd6, 10'd0); step(1);
    chk("R8 unforced relock", {p1(), p0()}, {1'b0, 2'd0, 4'h4, 1'b0, 2'd0, 4'h1});

    // R10 external pair selection alone
    rx_ql_i[15:8] = 8'h36;
    step(2);
    chk("R10 p1 selects B", p1(), {1'b1, 2'd0, 4'h3});
    chk("R10 p0 unchanged", p0(), {1'b0, 2'd0, 4'h1});

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule